// File: doc/BRIEF.md
# Codec Serial Control Sequencer

This block sits between a sample-processing datapath and a 16-bit serial audio codec link. It owns the codec's reset line and the write side of the serial transmit register. After reset it keeps the codec in reset for a programmable number of cycles, zeroes the transmit register, enables the serial port and releases the codec. It then loads a table of configuration words. Each configuration word is sent only after a secondary-request frame announces it.

Once configured, the block serves two kinds of request. A sample request sends one left-aligned 14-bit DAC sample in a primary frame, whose two low bits are 00. In the same cycle it captures the word the codec has returned and sign-extends the 14-bit ADC field held in its upper bits. An input-select request sends the held DAC sample with its two low bits forced to 11, which opens a one-shot secondary transfer. It then sends the control word that picks the primary or the auxiliary analog input. After that the link is back in primary mode. The serial shifter itself is outside the block. It is seen only through a transmit-ready flag and a load strobe.

Top module: `codec_link_seq`

## Requirements
- R1: From reset, `codec_rst_n` is low, `port_en` is low, `busy` is high and no write is issued. `codec_rst_n` stays low for exactly RST_CYC+1 clock cycles after reset is released.
- R2: The first write after reset has the value 0000h. It is issued without waiting for `tx_ready`, in the cycle in which `port_en` first goes high, while `codec_rst_n` is still low. `codec_rst_n` rises in the following cycle and is never high while `port_en` is low.
- R3: After release the block writes CFG_N pairs. Each pair is the secondary-request word 0003h followed by configuration entry i, for i = 0 up to CFG_N-1. Entry i sits in bits [16i+15:16i] of CFG_WORDS, and the default entries are 162Ch, 0001h, 4892h and 0067h. No other write occurs unless a request is served.
- R4: Apart from the clearing write, `tx_load` is high only in a cycle whose preceding clock edge saw `tx_ready` high. `tx_load` is never high in two consecutive cycles.
- R5: `busy` stays high from reset until the cycle of the last configuration write. A sample request made while `busy` is high is ignored and causes no write.
- R6: An accepted sample request produces one write of {smp_dac, 2'b00}, with `smp_ack` high in the same cycle as `tx_load`.
- R7: In the cycle of `smp_ack`, `smp_adc` equals `rx_word[15:2]` sign-extended from bit 15, as sampled at the edge that issued the write.
- R8: An accepted select request produces two writes. The first is {last accepted DAC sample, 2'b11}. The second is 0073h when `sel_aux` was 1 or 0063h when it was 0, with `sel_ack` high in that second cycle. The next sample frame is again primary (low bits 00).
- R9: When a select request and a sample request arrive in the same idle cycle, only the select is served. The sample request and its DAC value are dropped, and `smp_ack` and `sel_ack` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ready | input | 1 | Transmit buffer can accept a word; must fall within one cycle of a load |
| rx_word | input | 16 | Last word received from the codec |
| tx_load | output | 1 | One-cycle strobe writing `tx_word` into the transmit register |
| tx_word | output | 16 | Word to transmit |
| port_en | output | 1 | Serial port enable |
| codec_rst_n | output | 1 | Active-low codec reset |
| busy | output | 1 | High while the block cannot accept a request |
| smp_req | input | 1 | Sample exchange request, sampled while idle |
| smp_dac | input | 14 | DAC sample for the requested exchange |
| smp_ack | output | 1 | Sample frame written, `smp_adc` valid |
| smp_adc | output | 16 | Sign-extended ADC sample |
| sel_req | input | 1 | Input-select request, sampled while idle |
| sel_aux | input | 1 | 1 selects the auxiliary input, 0 the primary input |
| sel_ack | output | 1 | Select control word written |

## Verification
The bench shortens RST_CYC to 20 and keeps the default configuration table and control words. This makes the exact reset-hold length countable inside a short run while the full four-pair configuration order is still checked. The shifter model's ready latency is switched between 1, 3 and 7 cycles. This exercises writes that follow immediately on ready as well as long stalls in every wait state. The ADC patterns reach both extremes of the 14-bit range and nonzero low bits. The DAC patterns include all-ones and the sign boundary.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_CLEAR,
    ST_RELEASE,
    ST_W_SECREQ,
    ST_W_CFG,
    ST_IDLE,
    ST_W_SAMPLE,
    ST_W_SELFRM,
    ST_W_SELCTL
  } seq_state_t;

endpackage

// File: rtl/codec_rst_timer.sv
module codec_rst_timer #(
  parameter int HOLD_CYC = 100,
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC + 1) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == CNT_W'(HOLD_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(HOLD_CYC - 1)); // R1

endmodule

// File: rtl/codec_frame_pack.sv
module codec_frame_pack #(
  parameter int FRAME_W = 16,
  parameter int SMP_W   = 14,
  localparam int PAD_W  = FRAME_W - SMP_W
) (
  input  logic [SMP_W-1:0]   sample,
  input  logic               secondary,
  output logic [FRAME_W-1:0] frame
);

  assign frame = {sample, {PAD_W{secondary}}};

endmodule

// File: rtl/codec_rx_unpack.sv
module codec_rx_unpack #(
  parameter int FRAME_W = 16,
  parameter int SMP_W   = 14,
  parameter int OUT_W   = 16,
  localparam int PAD_W  = FRAME_W - SMP_W
) (
  input  logic [FRAME_W-1:0] word,
  output logic [OUT_W-1:0]   sample
);

  logic [SMP_W-1:0] field;
  logic             unused_pad;

  assign field      = word[FRAME_W-1:PAD_W];
  assign unused_pad = ^word[PAD_W-1:0];

  generate
    if (OUT_W > SMP_W) begin : g_extend
      assign sample = {{(OUT_W - SMP_W){field[SMP_W-1]}}, field};
    end else begin : g_exact
      assign sample = field[SMP_W-1 -: OUT_W];
    end
  endgenerate

endmodule

// File: rtl/codec_link_seq.sv
module codec_link_seq #(
  parameter int FRAME_W = 16,
  parameter int SMP_W   = 14,
  parameter int OUT_W   = 16,
  parameter int RST_CYC = 100,
  parameter int CFG_N   = 4,
  parameter logic [CFG_N*FRAME_W-1:0] CFG_WORDS =
    {16'h0067, 16'h4892, 16'h0001, 16'h162C},
  parameter logic [FRAME_W-1:0] SEC_REQ_WORD = 16'h0003,
  parameter logic [FRAME_W-1:0] SEL_PRI_WORD = 16'h0063,
  parameter logic [FRAME_W-1:0] SEL_AUX_WORD = 16'h0073
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_ready,
  input  logic [FRAME_W-1:0] rx_word,
  output logic               tx_load,
  output logic [FRAME_W-1:0] tx_word,
  output logic               port_en,
  output logic               codec_rst_n,
  output logic               busy,
  input  logic               smp_req,
  input  logic [SMP_W-1:0]   smp_dac,
  output logic               smp_ack,
  output logic [OUT_W-1:0]   smp_adc,
  input  logic               sel_req,
  input  logic               sel_aux,
  output logic               sel_ack
);

  import codec_seq_pkg::*;

  localparam int PAD_W = FRAME_W - SMP_W;
  localparam int IDX_W = (CFG_N > 1) ? $clog2(CFG_N) : 1;

  seq_state_t          state;
  logic [IDX_W-1:0]    idx;
  logic [SMP_W-1:0]    dac_hold;
  logic                aux_pick;
  logic                hold_done;
  logic                can_write;
  logic [FRAME_W-1:0]  frm_primary;
  logic [FRAME_W-1:0]  frm_select;
  logic [FRAME_W-1:0]  cfg_word;
  logic [OUT_W-1:0]    rx_sample;

  codec_rst_timer #(.HOLD_CYC(RST_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_HOLD),
    .expired (hold_done)
  );

  codec_frame_pack #(.FRAME_W(FRAME_W), .SMP_W(SMP_W)) u_pack_pri (
    .sample    (dac_hold),
    .secondary (1'b0),
    .frame     (frm_primary)
  );

  codec_frame_pack #(.FRAME_W(FRAME_W), .SMP_W(SMP_W)) u_pack_sec (
    .sample    (dac_hold),
    .secondary (1'b1),
    .frame     (frm_select)
  );

  codec_rx_unpack #(.FRAME_W(FRAME_W), .SMP_W(SMP_W), .OUT_W(OUT_W)) u_unpack (
    .word   (rx_word),
    .sample (rx_sample)
  );

  assign cfg_word  = CFG_WORDS[idx*FRAME_W +: FRAME_W];
  // a write in the previous cycle blocks the next one until ready is re-sampled
  assign can_write = tx_ready && !tx_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HOLD;
      idx         <= '0;
      dac_hold    <= '0;
      aux_pick    <= 1'b0;
      tx_load     <= 1'b0;
      tx_word     <= '0;
      port_en     <= 1'b0;
      codec_rst_n <= 1'b0;
      busy        <= 1'b1;
      smp_ack     <= 1'b0;
      smp_adc     <= '0;
      sel_ack     <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      smp_ack <= 1'b0;
      sel_ack <= 1'b0;
      case (state)
        ST_HOLD: begin
          if (hold_done) state <= ST_CLEAR;
        end
        ST_CLEAR: begin
          tx_load <= 1'b1;
          tx_word <= '0;
          port_en <= 1'b1;
          state   <= ST_RELEASE;
        end
        ST_RELEASE: begin
          codec_rst_n <= 1'b1;
          idx         <= '0;
          state       <= ST_W_SECREQ;
        end
        ST_W_SECREQ: begin
          if (can_write) begin
            tx_load <= 1'b1;
            tx_word <= SEC_REQ_WORD;
            state   <= ST_W_CFG;
          end
        end
        ST_W_CFG: begin
          if (can_write) begin
            tx_load <= 1'b1;
            tx_word <= cfg_word;
            if (idx == IDX_W'(CFG_N - 1)) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_W_SECREQ;
            end
          end
        end
        ST_IDLE: begin
          if (sel_req) begin
            aux_pick <= sel_aux;
            busy     <= 1'b1;
            state    <= ST_W_SELFRM;
          end else if (smp_req) begin
            dac_hold <= smp_dac;
            busy     <= 1'b1;
            state    <= ST_W_SAMPLE;
          end
        end
        ST_W_SAMPLE: begin
          if (can_write) begin
            tx_load <= 1'b1;
            tx_word <= frm_primary;
            smp_adc <= rx_sample;
            smp_ack <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        ST_W_SELFRM: begin
          if (can_write) begin
            tx_load <= 1'b1;
            tx_word <= frm_select;
            state   <= ST_W_SELCTL;
          end
        end
        ST_W_SELCTL: begin
          if (can_write) begin
            tx_load <= 1'b1;
            tx_word <= aux_pick ? SEL_AUX_WORD : SEL_PRI_WORD;
            sel_ack <= 1'b1;
            busy    <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  AST_CLEAR_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(codec_rst_n) |-> ($past(tx_load) && $past(tx_word) == '0)); // R2
  AST_PORT_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    codec_rst_n |-> port_en); // R2
  AST_WRITE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (tx_load && codec_rst_n) |-> $past(tx_ready)); // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load); // R4
  AST_BUSY_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !codec_rst_n |-> busy); // R5
  AST_SAMPLE_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    smp_ack |-> (tx_load && tx_word[PAD_W-1:0] == '0)); // R6
  AST_SELECT_CTRL: assert property (@(posedge clk) disable iff (rst)
    sel_ack |-> (tx_load && (tx_word == SEL_PRI_WORD || tx_word == SEL_AUX_WORD))); // R8
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smp_ack, sel_ack})); // R9

endmodule

// File: tb/codec_link_seq_tb.sv
module codec_link_seq_tb_top;

  localparam int TB_RST = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        tx_ready;
  logic [15:0] rx_word;
  logic        tx_load;
  logic [15:0] tx_word;
  logic        port_en;
  logic        codec_rst_n;
  logic        busy;
  logic        smp_req;
  logic [13:0] smp_dac;
  logic        smp_ack;
  logic [15:0] smp_adc;
  logic        sel_req;
  logic        sel_aux;
  logic        sel_ack;

  always #5 clk = ~clk;

  codec_link_seq #(.RST_CYC(TB_RST)) dut_i (
    .clk(clk), .rst(rst), .tx_ready(tx_ready), .rx_word(rx_word),
    .tx_load(tx_load), .tx_word(tx_word), .port_en(port_en),
    .codec_rst_n(codec_rst_n), .busy(busy), .smp_req(smp_req),
    .smp_dac(smp_dac), .smp_ack(smp_ack), .smp_adc(smp_adc),
    .sel_req(sel_req), .sel_aux(sel_aux), .sel_ack(sel_ack)
  );

  typedef struct packed {
    logic [15:0] word;
    logic [1:0]  kind;   // 0 plain, 1 sample, 2 select, 3 clear
    logic [15:0] adc;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    checks = 0;
  int    fails  = 0;
  int    writes = 0;
  int    lat    = 1;
  int    rdy_cnt;
  logic  ready_prev = 1'b1;
  logic  load_prev  = 1'b0;
  logic [13:0] last_dac = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(input logic [15:0] w);
    return {{2{w[15]}}, w[15:2]};
  endfunction

  task automatic expect_w(input logic [15:0] w, input logic [1:0] k,
                          input logic [15:0] a, input string tag);
    exp_t e;
    e.word = w; e.kind = k; e.adc = a;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // shifter model: ready drops after a load and returns after lat cycles
  always @(posedge clk) begin
    if (rst) begin
      tx_ready <= 1'b1;
      rdy_cnt  <= 0;
    end else if (tx_load) begin
      tx_ready <= 1'b0;
      rdy_cnt  <= lat;
    end else if (rdy_cnt != 0) begin
      rdy_cnt <= rdy_cnt - 1;
      if (rdy_cnt == 1) tx_ready <= 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_load) begin
        writes++;
        if (load_prev) chk(1'b0, "R4", "back-to-back write", 1, 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R3", "unexpected write", tx_word, 0);
        end else begin
          exp_t  e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(tx_word == e.word, t, "tx_word", tx_word, e.word);
          if (e.kind != 2'd3) chk(ready_prev, "R4", "write without ready", ready_prev, 1);
          case (e.kind)
            2'd1: begin
              chk(smp_ack && !sel_ack, "R6", "sample ack", {smp_ack, sel_ack}, 2'b10);
              chk(smp_adc == e.adc, "R7", "adc sample", smp_adc, e.adc);
            end
            2'd2: chk(sel_ack && !smp_ack, "R8", "select ack", {smp_ack, sel_ack}, 2'b01);
            2'd3: chk(!codec_rst_n && port_en, "R2", "clear with reset low, port on",
                      {codec_rst_n, port_en}, 2'b01);
            default: chk(!smp_ack && !sel_ack, "R9", "no ack", {smp_ack, sel_ack}, 0);
          endcase
        end
      end else if (smp_ack || sel_ack) begin
        chk(1'b0, "R9", "ack without write", {smp_ack, sel_ack}, 0);
      end
      ready_prev = tx_ready;
      load_prev  = tx_load;
    end
  end

  task automatic do_sample(input logic [13:0] dac, input logic [15:0] rx);
    while (busy) @(negedge clk);
    rx_word = rx;
    expect_w({dac, 2'b00}, 2'd1, sext(rx), "R6 R7");
    smp_dac = dac;
    smp_req = 1'b1;
    @(negedge clk);
    smp_req = 1'b0;
    while (busy) @(negedge clk);
    last_dac = dac;
  endtask

  task automatic do_select(input logic aux, input logic with_sample, input logic [13:0] dac);
    while (busy) @(negedge clk);
    expect_w({last_dac, 2'b11}, 2'd0, 16'h0, "R8");
    expect_w(aux ? 16'h0073 : 16'h0063, 2'd2, 16'h0, "R8");
    sel_aux = aux;
    sel_req = 1'b1;
    smp_dac = dac;
    smp_req = with_sample;
    @(negedge clk);
    sel_req = 1'b0;
    smp_req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int low;
    rst = 1'b1; smp_req = 1'b0; sel_req = 1'b0; sel_aux = 1'b0;
    smp_dac = '0; rx_word = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!codec_rst_n, "R1", "codec reset low", codec_rst_n, 0);
    chk(!port_en, "R1", "port disabled", port_en, 0);
    chk(busy, "R1", "busy in reset", busy, 1);
    chk(!tx_load, "R1", "no write in reset", tx_load, 0);

    expect_w(16'h0000, 2'd3, 16'h0, "R2");
    expect_w(16'h0003, 2'd0, 16'h0, "R3"); expect_w(16'h162C, 2'd0, 16'h0, "R3");
    expect_w(16'h0003, 2'd0, 16'h0, "R3"); expect_w(16'h0001, 2'd0, 16'h0, "R3");
    expect_w(16'h0003, 2'd0, 16'h0, "R3"); expect_w(16'h4892, 2'd0, 16'h0, "R3");
    expect_w(16'h0003, 2'd0, 16'h0, "R3"); expect_w(16'h0067, 2'd0, 16'h0, "R3");

    rst = 1'b0;
    @(negedge clk);
    low = 0;
    while (!codec_rst_n) begin
      low++;
      @(negedge clk);
    end
    chk(low == TB_RST + 1, "R1", "reset hold cycles", low, TB_RST + 1);

    // R5: request while configuring is ignored
    chk(busy, "R5", "busy during configuration", busy, 1);
    smp_dac = 14'h1234;
    smp_req = 1'b1;
    @(negedge clk);
    smp_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(writes == 9, "R5", "writes after init", writes, 9);
    chk(expq.size() == 0, "R3", "init sequence complete", expq.size(), 0);

    lat = 3;
    do_sample(14'h0155, 16'h1234);
    do_sample(14'h3FFF, 16'h8000);
    do_sample(14'h2000, 16'h7FFC);
    do_sample(14'h0001, 16'hFFFF);
    do_sample(14'h1ABC, 16'h0003);

    lat = 7;
    do_select(1'b1, 1'b0, 14'h0);
    do_sample(14'h0A5A, 16'hC004);   // primary again after select
    do_select(1'b0, 1'b0, 14'h0);

    lat = 1;
    do_select(1'b1, 1'b1, 14'h3333);  // R9: sample dropped
    do_select(1'b0, 1'b0, 14'h0);     // still uses held sample 0A5A
    do_sample(14'h0777, 16'h4000);

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R9", "no missing writes", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule